// File: doc/BRIEF.md
# Change-of-State Input Port Controller

This block is a bus-attached peripheral that samples 48 read-only digital inputs arranged as six 8-bit groups. A host sees it through an 8-byte register window driven by a 3-bit address, separate read and write strobes and an 8-bit data path. Six addresses return the live, synchronized levels of the groups. A seventh address is empty. The eighth address is shared: a write loads a per-group interrupt enable mask, and a read returns which groups have changed along with an active-low interrupt flag.

Every input passes through a synchronizer. A group reports a change when any of its eight synchronized inputs moves in either direction. A change in an enabled group sets that group's latched status bit. The interrupt request stays high while any status bit is set. Reading the shared address returns the status and clears it. A change detected in the same cycle as that read survives the clear and stays pending.

Top module: `cos_input_ctrl`

## Requirements
- R1: After reset the enable mask and all status bits are zero, `irq` is low, and a read of address 7 returns 0x40.
- R2: `rdata` is combinational from `addr`. Addresses 0, 1, 2, 4, 5 and 6 return the synchronized levels of inputs 0–7, 8–15, 16–23, 24–31, 32–39 and 40–47 in that order, with the lowest-numbered input of each group in bit 0. Address 3 reads 0x00.
- R3: A write (`wr_en` high at a clock edge) to address 7 loads `wdata[5:0]` as the enable mask, where bit g enables group g (inputs 8g to 8g+7). Writes to addresses 0–6 change nothing that is observable.
- R4: A rising or falling change on any input of a group whose enable bit is 1 sets status bit g. A change in a disabled group sets nothing.
- R5: A read of address 7 returns the status in bits 5:0, the inverse of `irq` in bit 6 (0 while an interrupt is pending), and 0 in bit 7. `irq` is high exactly when any status bit is set.
- R6: A read of address 7 clears every status bit at that clock edge. A change detected at that same edge is kept pending.
- R7: A write to address 7 clears the status bit of every group whose new enable bit is 0.
- R8: An input change made between two clock edges shows on `irq` after the third following rising edge and not before, because the input passes through two synchronizer stages and one edge-compare stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 48 | Raw external inputs |
| addr | input | 3 | Register address within the window |
| rd_en | input | 1 | Read strobe; a read of address 7 clears the status |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq | output | 1 | Interrupt request, high while any status bit is set |

## Verification
The bench builds the block with its default two-stage synchronizer, the depth the latency requirement is written for. With only 48 inputs and a 6-bit mask, this makes exhaustive sweeps practical: every input toggled in both directions with only its own group enabled and again with only its group disabled, all 64 enable masks against a full toggle of every input, and several level patterns read back through every address. The same setup gives exact-cycle checks of the interrupt latency, of a change that arrives at the edge where the status is read, and of status being cleared when its group is disabled.

// File: rtl/cos_input_ctrl.sv
module cos_input_ctrl #(
  parameter int SYNC_DEPTH = 2,
  localparam int NGRP = 6,
  localparam int GW = 8,
  localparam int NPIN = NGRP * GW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] din,
  input  logic [2:0]      addr,
  input  logic            rd_en,
  input  logic            wr_en,
  input  logic [7:0]      wdata,
  output logic [7:0]      rdata,
  output logic            irq
);

  localparam logic [2:0] CTL_ADDR = 3'd7;

  logic [NPIN-1:0] sync_q [SYNC_DEPTH];
  logic [NPIN-1:0] lvl, lvl_d;
  logic [NGRP-1:0] grp_chg, en_q, stat_q, stat_n;
  logic            ctl_rd, ctl_wr;

  assign lvl    = sync_q[SYNC_DEPTH-1];
  assign ctl_rd = rd_en && (addr == CTL_ADDR);
  assign ctl_wr = wr_en && (addr == CTL_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < SYNC_DEPTH; k++) sync_q[k] <= '0;
      lvl_d <= '0;
    end else begin
      sync_q[0] <= din;
      for (int k = 1; k < SYNC_DEPTH; k++) sync_q[k] <= sync_q[k-1];
      lvl_d <= lvl;
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_chg[g] = |(lvl[g*GW +: GW] ^ lvl_d[g*GW +: GW]);
  end

  always_comb begin
    stat_n = (ctl_rd ? '0 : stat_q) | (grp_chg & en_q);
    if (ctl_wr) stat_n = stat_n & wdata[NGRP-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      stat_q <= '0;
    end else begin
      stat_q <= stat_n;
      if (ctl_wr) en_q <= wdata[NGRP-1:0];
    end
  end

  assign irq = |stat_q;

  always_comb begin
    case (addr)
      3'd0:    rdata = lvl[7:0];
      3'd1:    rdata = lvl[15:8];
      3'd2:    rdata = lvl[23:16];
      3'd4:    rdata = lvl[31:24];
      3'd5:    rdata = lvl[39:32];
      3'd6:    rdata = lvl[47:40];
      3'd7:    rdata = {1'b0, ~irq, stat_q};
      default: rdata = 8'h00;
    endcase
  end

endmodule

module cos_input_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] addr,
  input logic       rd_en,
  input logic       wr_en,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       irq,
  input logic [5:0] en_q,
  input logic [5:0] stat_q,
  input logic [5:0] grp_chg
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (stat_q == '0 && en_q == '0 && !irq));

  // R2
  gap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) (addr == 3'd3) |-> (rdata == 8'h00));

  // R3
  ign_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != 3'd7) |=> (en_q == $past(en_q)));

  // R4
  only_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 3'd7) |=> ((stat_q & ~$past(stat_q) & ~$past(en_q)) == '0));

  // R5
  flag_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 3'd7) |-> (rdata[6] == !irq && rdata[7] == 1'b0));

  // R6
  clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd7 && !wr_en && grp_chg == '0) |=> !irq);

  // R6
  hold_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((rd_en || wr_en) && addr == 3'd7) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R7
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd7) |=> ((stat_q & ~$past(wdata[5:0])) == '0));

endmodule

bind cos_input_ctrl cos_input_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
  .wdata(wdata), .rdata(rdata), .irq(irq), .en_q(en_q), .stat_q(stat_q),
  .grp_chg(grp_chg)
);

// File: tb/cos_input_ctrl_tb.sv
module cos_input_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] pins = '0;
  logic [2:0]  addr = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cos_input_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .din(pins), .addr(addr), .rd_en(rd_en),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic settle();
    repeat (4) tick();
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    tick();
    rd_en = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] port_exp(input logic [47:0] p, input int a);
    case (a)
      0: return p[7:0];
      1: return p[15:8];
      2: return p[23:16];
      4: return p[31:24];
      5: return p[39:32];
      6: return p[47:40];
      default: return 8'h00;
    endcase
  endfunction

  initial begin
    logic [7:0] v;
    logic [7:0] junk;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    tick();

    rd(3'd7, v); chk("R1 reset status", v, 8'h40);
    chk("R1 reset irq", {7'd0, irq}, 8'h00);
    rd(3'd0, v); chk("R1 reset port", v, 8'h00);

    for (int k = 0; k < 8; k++) begin
      pins = 48'hA5A5_5A5A_0F0F ^ (48'(k) * 48'h0123_4567_89AB);
      settle();
      for (int a = 0; a < 7; a++) begin
        rd(3'(a), v); chk($sformatf("R2 port a=%0d", a), v, port_exp(pins, a));
      end
    end
    pins = '0; settle();

    wr(3'd7, 8'h3F); rd(3'd7, junk);
    pins[5] = ~pins[5];
    tick(); tick();
    chk("R8 irq before third edge", {7'd0, irq}, 8'h00);
    tick();
    chk("R8 irq after third edge", {7'd0, irq}, 8'h01);
    rd(3'd7, v); chk("R5 status flag low", v, 8'h01);
    rd(3'd7, v); chk("R6 cleared by read", v, 8'h40);

    pins[30] = ~pins[30];
    tick(); tick();
    rd(3'd7, v); chk("R6 read at detect edge", v, 8'h40);
    rd(3'd7, v); chk("R6 simultaneous kept", v, 8'h08);
    rd(3'd7, v); chk("R6 then cleared", v, 8'h40);

    wr(3'd7, 8'h03); rd(3'd7, junk);
    pins[0] = ~pins[0]; pins[8] = ~pins[8];
    settle();
    wr(3'd7, 8'h01);
    rd(3'd7, v); chk("R7 disabled group cleared", v, 8'h01);

    wr(3'd7, 8'h00); rd(3'd7, junk);
    for (int a = 0; a < 7; a++) wr(3'(a), 8'hFF);
    pins[20] = ~pins[20];
    settle();
    chk("R3 ignored writes irq", {7'd0, irq}, 8'h00);
    rd(3'd7, v); chk("R3 ignored writes status", v, 8'h40);
    rd(3'd2, v); chk("R3 port unchanged", v, pins[23:16]);

    for (int i = 0; i < 48; i++) begin
      int g;
      g = i / 8;
      wr(3'd7, 8'(1 << g)); rd(3'd7, junk);
      for (int e = 0; e < 2; e++) begin
        pins[i] = ~pins[i];
        settle();
        rd(3'd7, v);
        chk($sformatf("R4 pin %0d %s", i, pins[i] ? "rise" : "fall"), v, 8'(1 << g));
      end
      wr(3'd7, 8'(~(1 << g) & 8'h3F)); rd(3'd7, junk);
      pins[i] = ~pins[i];
      settle();
      rd(3'd7, v);
      chk($sformatf("R4 pin %0d disabled", i), v, 8'h40);
    end

    for (int m = 0; m < 64; m++) begin
      wr(3'd7, 8'(m)); rd(3'd7, junk);
      pins = ~pins;
      settle();
      chk($sformatf("R5 irq mask %0d", m), {7'd0, irq}, {7'd0, m != 0});
      rd(3'd7, v);
      chk($sformatf("R3 mask %0d", m), v, {1'b0, m == 0, 6'(m)});
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule